// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block runs the three register-operand control/status register instructions against a small CSR file that it holds itself. The three instructions are swap, bit-set and bit-clear. Each request carries an operation code, a 12-bit CSR address, a source operand, a flag that says whether the source register field was non-zero, and the current privilege level of the hart. The response returns the value the CSR held before the instruction, for the destination register, together with an illegal-instruction trap flag.

The three operations all use one masked-write primitive, `new = (old & ~mask) | (data & mask)`:

| Operation | data | mask |
|-----------|------|------|
| Swap | the source operand | all ones |
| Set | all ones | the source operand |
| Clear | all zeros | the source operand |

For set and clear, a zero source field forces the mask to zero, so the instruction only reads. An access is checked against three rules: the address must be implemented, the hart must be privileged enough, and a read-only region may not be written. If any rule fails, the instruction traps and changes nothing.

Requests arrive on a valid/ready channel and responses leave on another. The response is registered. It appears in the cycle after the request is accepted and is held until the consumer takes it. While an untaken response is pending, the unit refuses new requests, so a stalled consumer stalls the producer. The CSR file holds `NUM_REGS` registers, with addresses set by a parameter.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (op code 2'd1) replaces the whole CSR with the source operand, whether or not the source-field flag is set.
- R2: Set (op code 2'd2) with the source-field flag at 1 makes the new value the old value OR the source operand.
- R3: Clear (op code 2'd3) with the source-field flag at 1 makes the new value the old value AND NOT the source operand.
- R4: For set and clear, a source-field flag of 0 uses a zero mask. The CSR is left unchanged, and the instruction is then only a read.
- R5: A legal access returns the CSR contents from before the write in rsp_data with rsp_trap at 0. A trapped access returns rsp_data 0 with rsp_trap at 1.
- R6: An access traps and writes nothing when the privilege level (0 user, 1 supervisor, 3 machine) is numerically below address bits [9:8].
- R7: When address bits [11:10] equal 2'b11, an access traps and writes nothing if its mask is non-zero. An access there with a zero mask is legal, including a set with a zero operand.
- R8: An address outside the implemented list traps. So does op code 2'd0.
- R9: rsp_valid rises in the cycle after req_valid and req_ready are both high. rsp_valid, rsp_data and rsp_trap hold steady while rsp_ready is low. req_ready equals (not rsp_valid) or rsp_ready.
- R10: After reset, rsp_valid is 0 and register i of the list holds 32'h11111111 times (i+1). The default list, from index 0, is 000, 001, 100, 140, 300, 340, C00, F11 (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request is present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 2 | 1 swap, 2 set, 3 clear, 0 invalid |
| req_addr | input | 12 | CSR address |
| req_src | input | XLEN | Source operand |
| req_rs_nz | input | 1 | Source register field is non-zero |
| req_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response is present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | XLEN | Old CSR value, or 0 on a trap |
| rsp_trap | output | 1 | Illegal-instruction trap |

## Verification
The assertions assume the producer keeps the request fields stable while req_valid is high. They also assume the consumer obeys the handshake: it drives rsp_ready as an input and never expects data while rsp_valid is low. The stimulus changes request fields only on the falling edge, and only before the request is accepted, and it deasserts req_valid in the cycle after acceptance. Privilege values are drawn only from 0, 1 and 3. Addresses come from the implemented list and from a few unimplemented ones, so every trap path is reached without ever giving the unit an undefined input.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SWAP  = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0] RO_REGION = 2'b11;

  // Reset image of register idx in the list
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return 32'h11111111 * 32'(idx + 1);
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int NUM_REGS = 8,
  parameter int IDX_W = 3,
  parameter logic [NUM_REGS-1:0][11:0] CSR_ADDRS = '0
) (
  input  logic [11:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [NUM_REGS-1:0] match;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
    assign match[g] = (addr == CSR_ADDRS[g]);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;

endmodule

// File: rtl/csr_mask_gen.sv
module csr_mask_gen
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e          op,
  input  logic [XLEN-1:0]  src,
  input  logic             rs_nz,
  output logic [XLEN-1:0]  wdata,
  output logic [XLEN-1:0]  wmask,
  output logic             op_ok
);

  always_comb begin
    wdata = '0;
    wmask = '0;
    op_ok = 1'b1;
    unique case (op)
      OP_SWAP: begin
        wdata = src;
        wmask = '1;
      end
      OP_SET: begin
        wdata = '1;
        wmask = rs_nz ? src : '0;
      end
      OP_CLEAR: begin
        wdata = '0;
        wmask = rs_nz ? src : '0;
      end
      default: op_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [XLEN-1:0]  wr_mask
);

  logic [NUM_REGS-1:0][XLEN-1:0] q;
  logic [NUM_REGS-1:0][XLEN-1:0] nxt;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    assign nxt[g] = (wr_en && idx == IDX_W'(g))
                  ? ((q[g] & ~wr_mask) | (wr_data & wr_mask))
                  : q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) q[i] <= XLEN'(seed_word(i));
    end else begin
      q <= nxt;
    end
  end

  assign rd_data = q[idx];

  // R4 / R6 / R7: without a write strobe no register moves
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS-1:0][11:0] CSR_ADDRS = {
    12'hF11, 12'hC00, 12'h340, 12'h300, 12'h140, 12'h100, 12'h001, 12'h000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [11:0]     req_addr,
  input  logic [XLEN-1:0] req_src,
  input  logic            req_rs_nz,
  input  logic [1:0]      req_priv,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [XLEN-1:0] rsp_data,
  output logic            rsp_trap
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [XLEN-1:0]  wr_data, wr_mask, old_val;
  logic             op_ok, priv_low, ro_block, illegal, accept, wr_en;

  csr_addr_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CSR_ADDRS(CSR_ADDRS)) u_dec (
    .addr(req_addr), .hit(dec_hit), .idx(dec_idx));

  csr_mask_gen #(.XLEN(XLEN)) u_mask (
    .op(csr_op_e'(req_op)), .src(req_src), .rs_nz(req_rs_nz),
    .wdata(wr_data), .wmask(wr_mask), .op_ok(op_ok));

  csr_regfile #(.XLEN(XLEN), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .idx(dec_idx), .rd_data(old_val),
    .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign priv_low  = req_priv < req_addr[9:8];
  assign ro_block  = (req_addr[11:10] == RO_REGION) && (|wr_mask);
  assign illegal   = !dec_hit || !op_ok || priv_low || ro_block;
  assign wr_en     = accept && !illegal && (|wr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_trap  <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= illegal ? '0 : old_val;
      rsp_trap  <= illegal;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_resp_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_resp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_trap)));

  assert_priv_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_priv < req_addr[9:8])) |=> rsp_trap);

  assert_ro_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[11:10] == 2'b11 && wr_mask != '0) |=> rsp_trap);

  assert_unimpl_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !dec_hit) |=> (rsp_trap && rsp_data == '0));

endmodule

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [11:0] req_addr = 12'h0;
  logic [31:0] req_src = 32'h0;
  logic        req_rs_nz = 1'b0;
  logic [1:0]  req_priv = 2'd3;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_trap;
  logic [31:0] rsp_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [11:0] addr_list [N] = '{12'h000, 12'h001, 12'h100, 12'h140,
                                 12'h300, 12'h340, 12'hC00, 12'hF11};
  logic [31:0] model [N];

  always #10 clk = ~clk;

  csr_rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_src(req_src), .req_rs_nz(req_rs_nz),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_trap(rsp_trap));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements; updates model[] on legal writes
  task automatic predict(input logic [1:0] op, input logic [11:0] addr,
                         input logic [1:0] priv, input logic nz, input logic [31:0] src,
                         output logic trap, output logic [31:0] rd, output string tag);
    int idx = -1;
    logic [31:0] mask, data;
    for (int i = 0; i < N; i++) if (addr_list[i] == addr) idx = i;
    mask = (op == 2'd1) ? 32'hFFFF_FFFF : (nz ? src : 32'h0);
    data = (op == 2'd1) ? src : (op == 2'd2) ? 32'hFFFF_FFFF : 32'h0;
    if (idx < 0 || op == 2'd0) begin trap = 1; tag = "R8"; end
    else if (priv < addr[9:8]) begin trap = 1; tag = "R6"; end
    else if (addr[11:10] == 2'b11 && mask != 0) begin trap = 1; tag = "R7"; end
    else begin
      trap = 0;
      if (op != 2'd1 && !nz) tag = "R4";
      else if (op == 2'd1) tag = "R1";
      else if (op == 2'd2) tag = "R2";
      else tag = "R3";
    end
    if (addr[11:10] == 2'b11 && !trap) tag = "R7";
    rd = trap ? 32'h0 : model[idx];
    if (!trap) model[idx] = (model[idx] & ~mask) | (data & mask);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [11:0] addr,
                        input logic [1:0] priv, input logic nz, input logic [31:0] src,
                        input int hold);
    logic et;
    logic [31:0] ed;
    string tag;
    predict(op, addr, priv, nz, src, et, ed, tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_priv = priv;
    req_rs_nz = nz; req_src = src; rsp_ready = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, "R9 valid after accept", 64'(rsp_valid), 64'd1);
    check(rsp_trap === et, {tag, " trap"}, 64'(rsp_trap), 64'(et));
    check(rsp_data === ed, {tag, " R5 data"}, 64'(rsp_data), 64'(ed));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_data === ed && rsp_trap === et && req_ready === 1'b0,
            "R9 hold under back-pressure", {31'h0, rsp_valid, rsp_data}, {31'h0, 1'b1, ed});
    end
    check(req_ready === 1'b0 || hold == 0, "R9 ready while pending", 64'(req_ready), 64'd0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(rsp_valid === 1'b0, "R9 valid drops after take", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) model[i] = 32'h11111111 * 32'(i + 1);
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R10 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R10 idle after reset",
          {62'h0, rsp_valid, req_ready}, 64'd1);
    // R10: reset images via pure reads
    for (int i = 0; i < N; i++) run_op(2'd2, addr_list[i], 2'd3, 1'b0, 32'hFFFF_FFFF, 0);
    // Directed corners
    run_op(2'd1, 12'h300, 2'd3, 1'b0, 32'hDEAD_BEEF, 1);   // R1 swap without flag
    run_op(2'd2, 12'h300, 2'd3, 1'b1, 32'h0000_00F0, 2);   // R2
    run_op(2'd3, 12'h300, 2'd3, 1'b1, 32'h0000_000F, 0);   // R3
    run_op(2'd3, 12'h300, 2'd3, 1'b0, 32'hFFFF_FFFF, 0);   // R4 clear suppressed
    run_op(2'd2, 12'h300, 2'd3, 1'b0, 32'hFFFF_FFFF, 0);   // R4 read back
    run_op(2'd1, 12'h340, 2'd1, 1'b1, 32'h1234_5678, 0);   // R6 supervisor into machine
    run_op(2'd2, 12'h100, 2'd0, 1'b1, 32'h1, 0);           // R6 user into supervisor
    run_op(2'd1, 12'hC00, 2'd3, 1'b1, 32'h0, 0);           // R7 swap into read-only
    run_op(2'd2, 12'hF11, 2'd3, 1'b1, 32'h0, 0);           // R7 zero-mask set allowed
    run_op(2'd3, 12'hF11, 2'd3, 1'b1, 32'h4, 3);           // R7 nonzero clear traps
    run_op(2'd1, 12'h7FF, 2'd3, 1'b1, 32'h5, 0);           // R8 unimplemented
    run_op(2'd0, 12'h000, 2'd3, 1'b1, 32'h5, 0);           // R8 op code 0
    run_op(2'd2, 12'h340, 2'd3, 1'b0, 32'h0, 0);           // R6 no write happened
    // Constrained random
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      logic [1:0] p;
      int r = int'($urandom_range(0, 9));
      a = (r < 8) ? addr_list[r] : ((r == 8) ? 12'h2C0 : 12'hB05);
      r = int'($urandom_range(0, 2));
      p = (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : 2'd3;
      run_op(2'($urandom_range(0, 3)), a, p, 1'($urandom_range(0, 1)), $urandom,
             int'($urandom_range(0, 3)));
    end
    // Final read-back of every register
    for (int i = 0; i < N; i++) run_op(2'd2, addr_list[i], 2'd3, 1'b0, 32'h0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule